// File: doc/BRIEF.md
# Programmable Butterfly Pattern Network

This block transforms a 64-bit word through a chain of butterfly rows. Row k pairs every bit with the bit 2^k positions away. When a row is active, each bit is replaced by the output of a two-input lookup function. The function's inputs are the lower and the upper bit of its pair. Each row carries two such functions: one for the lower element of every pair and one for the upper element. A single function pair can therefore swap, OR-combine, XOR-fold or leave the word unchanged, row by row.

The starting word is either the supplied operand or a built-in alternating constant, and it may be complemented before the first row. This lets one operation produce a large family of regular bit patterns, such as sparse lane masks and sign-bit masks, with no operand at all. Two stage-selection modes exist. In shift mode, one 8-bit function pair is shared by every row, and the low bits of operand B choose which rows act. In per-row mode, every row acts and row i takes its own function pair from byte i of operand B. A half-word mode confines the work to the low 32 bits. The result is registered, one clock after the inputs.

Top module: `grevlut_net`

## Requirements
- R1: With `use_const` high the starting word is 0x5555_5555_5555_5555, otherwise it is `src_a`.
- R2: With `invert` high the starting word is complemented before the first row, so a constant start with invert gives 0xAAAA_AAAA_AAAA_AAAA.
- R3: In shift mode (`row_mode` low), row k (chunk 2^k, k = 0..5) acts only when bit k of `src_b` is set. `src_b` bits above bit 5 have no effect.
- R4: In an active row, bit j with (j & chunk) == 0 uses `lut_imm[3:0]` and the other bits use `lut_imm[7:4]`. The lookup index is (lower bit of the pair)*2 + (upper bit of the pair), and the new bit is nibble[index].
- R5: `lut_imm` = 0xCA swaps the pair, so shift mode yields the generalised reverse: result bit j = start bit (j XOR shift amount).
- R6: `lut_imm` = 0xEE ORs each bit with its partner, so shift mode yields the generalised OR-combine.
- R7: With a constant start, no invert and `lut_imm` = 0x6C, `src_b` = 0b10, 0b110 and 0b1110 give 0x1111…, 0x0101… and 0x00010001….
- R8: With a constant start, invert set and `lut_imm` = 0xC6, `src_b` = 0b10, 0b110 and 0b1110 give 0x8888…, 0x8080… and 0x80008000….
- R9: In per-row mode every row acts and row i uses byte i of `src_b` as its function pair, in place of `lut_imm`. Pair 0xAC leaves a row unchanged and pair 0xCA swaps it.
- R10: In half-word mode only rows 0..4 act, on the low 32 bits. Result bits 63:32 are zero, and `src_b` bit 5 has no effect.
- R11: While `rst` is high the result is zero. Otherwise the result reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_const | input | 1 | Start from the alternating constant instead of `src_a` |
| src_a | input | 64 | Operand used as the starting word |
| src_b | input | 64 | Shift amount (shift mode) or per-row function pairs (per-row mode) |
| lut_imm | input | 8 | Shared function pair: low nibble for lower elements, high nibble for upper |
| invert | input | 1 | Complement the starting word |
| half_word | input | 1 | Confine the operation to the low 32 bits |
| row_mode | input | 1 | 1 = per-row function pairs, 0 = shift-selected rows |
| result | output | 64 | Registered network output |

## Verification
The hardest condition to bring about is a disagreement between the two halves of a row, which shows whether the lower and upper elements use the correct nibble and index order. Symmetric pairs such as the XOR-based pattern immediates hide that ordering. The stimulus therefore drives one-hot nibbles on one- and two-bit operands, where only one index ordering can light the output bit. Per-row mode is reached with byte-mixed B operands that interleave identity, swap and pattern rows. Half-word mode is checked with and without B bit 5, and that bit must not change the outcome.

// File: rtl/grl_pkg.sv
package grl_pkg;

    // One row's function pair: high nibble for upper elements, low for lower
    typedef struct packed {
        logic [3:0] hi_fn;
        logic [3:0] lo_fn;
    } lut_pair_t;

    typedef enum logic {
        SEL_SHAMT = 1'b0,
        SEL_ROW   = 1'b1
    } row_sel_e;

    // Index = lower-element bit * 2 + upper-element bit
    function automatic logic lut2_eval(input logic [3:0] fn,
                                       input logic lower_bit,
                                       input logic upper_bit);
        return fn[{lower_bit, upper_bit}];
    endfunction

endpackage

// File: rtl/grl_seed.sv
module grl_seed #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] operand,
    input  logic             use_const,
    input  logic             invert,
    output logic [WIDTH-1:0] seed
);
    localparam logic [WIDTH-1:0] ALT_PAT = {(WIDTH/2){2'b01}};

    logic [WIDTH-1:0] base;

    always_comb begin
        base = use_const ? ALT_PAT : operand;
        seed = invert ? ~base : base;
    end
endmodule

// File: rtl/grl_ctrl.sv
module grl_ctrl
    import grl_pkg::*;
#(
    parameter int WIDTH  = 64,
    parameter int STAGES = 6
) (
    input  logic [WIDTH-1:0]              ctl_b,
    input  logic [7:0]                    imm,
    input  logic                          half,
    input  row_sel_e                      mode,
    output logic [STAGES-1:0]             stage_en,
    output lut_pair_t [STAGES-1:0]        stage_fn
);
    localparam int LAST     = STAGES - 1;
    localparam int ROW_BITS = 8 * STAGES;

    for (genvar k = 0; k < STAGES; k++) begin : g_row
        logic live;
        assign live        = (k != LAST) || !half;
        assign stage_en[k] = live && ((mode == SEL_ROW) || ctl_b[k]);
        assign stage_fn[k] = (mode == SEL_ROW) ? lut_pair_t'(ctl_b[8*k +: 8])
                                               : lut_pair_t'(imm);
    end

    if (WIDTH > ROW_BITS) begin : g_spare
        logic unused_b_hi;
        assign unused_b_hi = ^ctl_b[WIDTH-1:ROW_BITS];
    end
endmodule

// File: rtl/grl_stage.sv
module grl_stage
    import grl_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int CHUNK = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    input  lut_pair_t        fn,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] mixed;

    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
        if ((j & CHUNK) == 0) begin : g_lo
            assign mixed[j] = lut2_eval(fn.lo_fn, din[j], din[j+CHUNK]);
        end else begin : g_hi
            assign mixed[j] = lut2_eval(fn.hi_fn, din[j-CHUNK], din[j]);
        end
    end

    assign dout = en ? mixed : din;
endmodule

// File: rtl/grevlut_net.sv
module grevlut_net
    import grl_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             use_const,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic [7:0]       lut_imm,
    input  logic             invert,
    input  logic             half_word,
    input  logic             row_mode,
    output logic [WIDTH-1:0] result
);
    localparam int STAGES = $clog2(WIDTH);
    localparam int HALF   = WIDTH / 2;
    localparam logic [WIDTH-1:0] ALT_PAT = {HALF{2'b01}};

    row_sel_e                   mode_sel;
    logic [STAGES-1:0]          stage_en;
    lut_pair_t [STAGES-1:0]     stage_fn;
    logic [STAGES:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]           next_val;

    assign mode_sel = row_mode ? SEL_ROW : SEL_SHAMT;

    grl_seed #(.WIDTH(WIDTH)) u_seed (
        .operand   (src_a),
        .use_const (use_const),
        .invert    (invert),
        .seed      (chain[0])
    );

    grl_ctrl #(.WIDTH(WIDTH), .STAGES(STAGES)) u_ctrl (
        .ctl_b    (src_b),
        .imm      (lut_imm),
        .half     (half_word),
        .mode     (mode_sel),
        .stage_en (stage_en),
        .stage_fn (stage_fn)
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        grl_stage #(.WIDTH(WIDTH), .CHUNK(1 << k)) u_row (
            .din  (chain[k]),
            .en   (stage_en[k]),
            .fn   (stage_fn[k]),
            .dout (chain[k+1])
        );
    end

    assign next_val = half_word ? {{HALF{1'b0}}, chain[STAGES][HALF-1:0]}
                                : chain[STAGES];

    always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= next_val;
    end

    AST_CONST_SEED: assert property (@(posedge clk) disable iff (rst)
        (!row_mode && use_const && !invert && !half_word && src_b[STAGES-1:0] == '0)
        |=> result == ALT_PAT); // R1

    AST_INVERT_SEED: assert property (@(posedge clk) disable iff (rst)
        (!row_mode && use_const && invert && !half_word && src_b[STAGES-1:0] == '0)
        |=> result == ~ALT_PAT); // R2

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (!row_mode && !use_const && !invert && !half_word && src_b[STAGES-1:0] == '0)
        |=> result == $past(src_a)); // R3

    AST_PAIR_SWAP: assert property (@(posedge clk) disable iff (rst)
        (!row_mode && !use_const && !invert && !half_word && lut_imm == 8'hCA
         && src_b[STAGES-1:0] == 1)
        |=> result == ((($past(src_a) & ALT_PAT) << 1) | (($past(src_a) & ~ALT_PAT) >> 1))); // R5

    AST_ROW_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (row_mode && !use_const && !invert && !half_word
         && src_b[8*STAGES-1:0] == {STAGES{8'hAC}})
        |=> result == $past(src_a)); // R9

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        half_word |=> result[WIDTH-1:HALF] == '0); // R10
endmodule

// File: tb/tb_grevlut_net.sv
module tb_grevlut_net;
    logic        clk = 1'b0;
    logic        rst;
    logic        use_const;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [7:0]  lut_imm;
    logic        invert;
    logic        half_word;
    logic        row_mode;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    grevlut_net dut (
        .clk(clk), .rst(rst), .use_const(use_const), .src_a(src_a),
        .src_b(src_b), .lut_imm(lut_imm), .invert(invert),
        .half_word(half_word), .row_mode(row_mode), .result(result)
    );

    // Behavioural reference built from the requirements
    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [7:0] imm, input logic inv,
                                          input logic half, input logic cst,
                                          input logic per);
        logic [63:0] x, y;
        int rows;
        x = cst ? 64'h5555_5555_5555_5555 : a;
        if (inv) x = ~x;
        rows = half ? 5 : 6;
        for (int k = 0; k < rows; k++) begin
            int c;
            logic [7:0] fp;
            c = 1 << k;
            fp = per ? b[8*k +: 8] : imm;
            if (per || b[k]) begin
                for (int j = 0; j < 64; j++) begin
                    int lo, hi, idx;
                    lo = ((j & c) == 0) ? j : (j - c);
                    hi = lo + c;
                    idx = (x[lo] ? 2 : 0) + (x[hi] ? 1 : 0);
                    y[j] = ((j & c) == 0) ? fp[idx] : fp[4 + idx];
                end
                x = y;
            end
        end
        if (half) x[63:32] = '0;
        return x;
    endfunction

    function automatic logic [63:0] grev_ref(input logic [63:0] a, input int s);
        logic [63:0] r;
        for (int j = 0; j < 64; j++) r[j] = a[j ^ s];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic op(input logic [63:0] a, input logic [63:0] b, input logic [7:0] imm,
                      input logic inv, input logic half, input logic cst,
                      input logic per, output logic [63:0] got);
        @(negedge clk);
        src_a = a; src_b = b; lut_imm = imm; invert = inv;
        half_word = half; use_const = cst; row_mode = per;
        @(posedge clk);
        #1 got = result;
    endtask

    task automatic op_chk(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic [7:0] imm, input logic inv, input logic half,
                          input logic cst, input logic per, input logic [63:0] exp);
        logic [63:0] got;
        op(a, b, imm, inv, half, cst, per, got);
        check(req, got, exp);
        check({req, " model"}, got, model(a, b, imm, inv, half, cst, per));
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] g1, g2, a;
        rst = 1'b1; use_const = 1'b1; src_a = 64'hDEAD_BEEF_0123_4567;
        src_b = 64'h3F; lut_imm = 8'hEE; invert = 1'b1; half_word = 1'b0; row_mode = 1'b0;
        repeat (3) @(posedge clk);
        #1 check("R11 reset", result, 64'h0);
        @(negedge clk) rst = 1'b0;

        // R1 / R2 seeds
        op_chk("R1 const", 64'h1234, 64'h0, 8'hCA, 0, 0, 1, 0, 64'h5555_5555_5555_5555);
        op_chk("R1 operand", 64'hF0E1_D2C3_B4A5_9687, 64'h0, 8'h6C, 0, 0, 0, 0, 64'hF0E1_D2C3_B4A5_9687);
        op_chk("R2 const inv", 64'h0, 64'h0, 8'hCA, 1, 0, 1, 0, 64'hAAAA_AAAA_AAAA_AAAA);
        op_chk("R2 operand inv", 64'h00FF_0000_1234_8000, 64'h0, 8'hCA, 1, 0, 0, 0, ~64'h00FF_0000_1234_8000);

        // R4 index order and nibble placement
        op_chk("R4 lower nibble", 64'h2, 64'h1, 8'h02, 0, 0, 0, 0, 64'h1);
        op_chk("R4 upper nibble", 64'h2, 64'h1, 8'h20, 0, 0, 0, 0, 64'h2);
        op_chk("R4 index order", 64'h1, 64'h1, 8'h02, 0, 0, 0, 0, 64'h0);

        // R5 generalised reverse
        a = 64'h0123_4567_89AB_CDEF;
        foreach (g1[s]) begin end
        for (int s = 1; s < 64; s += 13)
            op_chk("R5 grev", a, 64'(s), 8'hCA, 0, 0, 0, 0, grev_ref(a, s));
        op_chk("R5 grev full", a, 64'd63, 8'hCA, 0, 0, 0, 0, grev_ref(a, 63));

        // R6 OR-combine
        op_chk("R6 gorc one row", 64'h1, 64'h1, 8'hEE, 0, 0, 0, 0, 64'h3);
        op_chk("R6 gorc byte", 64'h80, 64'h7, 8'hEE, 0, 0, 0, 0, 64'hFF);
        op_chk("R6 gorc all", 64'h1, 64'd63, 8'hEE, 0, 0, 0, 0, '1);

        // R7 / R8 pattern constants
        op_chk("R7 nibble mask", 0, 64'b10, 8'h6C, 0, 0, 1, 0, 64'h1111_1111_1111_1111);
        op_chk("R7 byte mask", 0, 64'b110, 8'h6C, 0, 0, 1, 0, 64'h0101_0101_0101_0101);
        op_chk("R7 half mask", 0, 64'b1110, 8'h6C, 0, 0, 1, 0, 64'h0001_0001_0001_0001);
        op_chk("R8 nibble sign", 0, 64'b10, 8'hC6, 1, 0, 1, 0, 64'h8888_8888_8888_8888);
        op_chk("R8 byte sign", 0, 64'b110, 8'hC6, 1, 0, 1, 0, 64'h8080_8080_8080_8080);
        op_chk("R8 half sign", 0, 64'b1110, 8'hC6, 1, 0, 1, 0, 64'h8000_8000_8000_8000);

        // R3 bits of B above the row count are ignored
        op_chk("R3 high B ignored", 0, 64'hFFFF_FFFF_FFFF_FFC2, 8'h6C, 0, 0, 1, 0, 64'h1111_1111_1111_1111);
        op_chk("R3 row off", a, 64'hFFFF_FFFF_FFFF_FFC0, 8'hEE, 0, 0, 0, 0, a);

        // R9 per-row pairs
        op_chk("R9 identity rows", a, 64'h0000_ACAC_ACAC_ACAC, 8'h00, 0, 0, 0, 1, a);
        op_chk("R9 swap rows", a, 64'h0000_CACA_CACA_CACA, 8'hAC, 0, 0, 0, 1, grev_ref(a, 63));
        op_chk("R9 mixed rows", 0, 64'hFFFF_ACAC_ACAC_6CAC, 8'hCA, 0, 0, 1, 1, 64'h1111_1111_1111_1111);

        // R10 half-word mode
        op_chk("R10 half grev", a, 64'd31, 8'hCA, 0, 1, 0, 0, {32'h0, grev_ref(a, 31) >> 0} & 64'hFFFF_FFFF);
        op(a, 64'd63, 8'hCA, 0, 1, 0, 0, g1);
        op(a, 64'd31, 8'hCA, 0, 1, 0, 0, g2);
        check("R10 bit5 ignored", g1, g2);
        op_chk("R10 half const", 0, 64'b1110, 8'h6C, 0, 1, 1, 0, 64'h0000_0000_0001_0001);
        op_chk("R10 half ones", 0, 64'h0, 8'hCA, 1, 1, 1, 0, 64'h0000_0000_AAAA_AAAA);

        // Randomised clock-by-clock comparison against the model (R3, R4, R9, R10)
        for (int i = 0; i < 300; i++) begin
            logic [63:0] ra, rb, got;
            logic [7:0] ri;
            logic [4:0] fl;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            ri = 8'($urandom);
            fl = 5'($urandom);
            op(ra, rb, ri, fl[0], fl[1], fl[2], fl[3], got);
            check("R4 random", got, model(ra, rb, ri, fl[0], fl[1], fl[2], fl[3]));
        end

        // R11 reset clears a live result
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 check("R11 reset again", result, 64'h0);
        @(negedge clk) rst = 1'b0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule